// File: doc/BRIEF.md
# Enabled-Channel Conversion Readout Sequencer

This block stands in for an eight-input converter that samples all of its inputs at the same moment. Each result is then delivered in turn through a narrow read port. A start pulse freezes every 12-bit input in one clock. After that, results for the channels marked in an enable mask become ready one slot at a time. The first result takes a longer lead-in, and each further result takes a shorter, fixed step. Fewer enabled channels therefore finish sooner.

Reads from the port walk only the enabled channels, from the lowest-numbered to the highest. Disabled channels are never converted and are never returned. A read that arrives before its result is ready is refused with a wait indication, and the pointer stays where it is. Two active-low flags tell a poller or an interrupt line when the first result is ready and when the last one is. Slot timing comes from nanosecond parameters and the clock frequency.

Top module: `conv_readout_seq`

## Requirements
- R1: The enable mask register (bit c enables channel c) resets to 8'hFF. It loads `cfg_mask` on a cycle with `cfg_we` high. Each conversion uses the mask value held when its start is sampled.
- R2: The clock edge that samples `start` high captures all eight inputs. Changes to `samples` after that edge do not alter the results of that conversion. Channel c occupies `samples[12c+11:12c]`.
- R3: Successive accepted reads return the enabled channels in ascending channel order, one per read, and skip disabled channels.
- R4: An accepted data read yields `rd_data` = {4'hF, 12-bit result}, with the result in bits 11:0 and bit 0 as the LSB.
- R5: The first result is ready, and `eoc_n` falls to 0, at the clock edge FIRST_CYC edges after the start edge (FIRST_CYC = FIRST_NS·CLK_MHZ/1000, 225 by default).
- R6: Result k (k counted from 0) is ready SLOT_CYC·k edges after the first (SLOT_CYC = 50 by default). `eolc_n` falls to 0 at the edge where the last enabled result becomes ready.
- R7: A read sampled while its result is not yet ready gives `rd_wait`=1 and `rd_valid`=0 in the next cycle. `rd_data` is unchanged and the read pointer does not advance.
- R8: A read sampled after all enabled results have been read gives `rd_valid`=1 with `rd_data`=16'hFFFF.
- R9: A start restarts the read pointer at the lowest enabled channel. It drives both flags back to 1 in the next cycle, unless the mask is empty.
- R10: A start with an all-zero mask drives both flags to 0 in the next cycle. Every following read returns 16'hFFFF with `rd_valid`=1.
- R11: After reset both flags are 1 and `rd_valid`/`rd_wait` are 0. Reads before the first start return 16'hFFFF with `rd_valid`=1.
- R12: When `start` and `rd` are high in the same cycle, the start takes effect and the read is dropped: `rd_valid`=`rd_wait`=0 in the next cycle.
- R13: `rd_valid` and `rd_wait` are never both 1. Each reflects only the read sampled at the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the enable mask register |
| cfg_mask | input | 8 | New enable mask, bit c enables channel c |
| start | input | 1 | Begin a conversion (one-cycle pulse) |
| rd | input | 1 | Read strobe, one result per accepted cycle |
| samples | input | 96 | Eight 12-bit inputs, channel c at bits 12c+11:12c |
| rd_data | output | 16 | Registered read word |
| rd_valid | output | 1 | The read of the previous cycle was accepted |
| rd_wait | output | 1 | The read of the previous cycle was refused as not ready |
| eoc_n | output | 1 | Active-low: first result ready |
| eolc_n | output | 1 | Active-low: last enabled result ready |

## Verification
The bench aims reads at the exact edge where a slot completes. A design that is off by one there would return a result one cycle early, or stall one cycle too long. It runs sparse masks and changes the inputs straight after the start edge. That exposes a readout that walks disabled channels, or one that reads live inputs instead of captured ones. It also restarts in the middle of a readout, starts with an empty mask, raises start and read together, and reads past the end. A design that keeps a stale pointer, hangs on an empty mask, or returns garbage instead of all ones then shows the wrong word or the wrong flag in the cycle concerned.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    RESP_IDLE = 2'd0,
    RESP_DATA = 2'd1,
    RESP_PAD  = 2'd2,
    RESP_WAIT = 2'd3
  } resp_e;
endpackage

// File: rtl/capture_store.sv
module capture_store #(
  parameter int CH = 8,
  parameter int DW = 12,
  localparam int IW = $clog2(CH)
) (
  input  logic               clk,
  input  logic               start,
  input  logic [CH-1:0]      mask,
  input  logic [CH*DW-1:0]   samples,
  input  logic [IW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_word
);
  logic [DW-1:0] packed_res [CH];
  logic [DW-1:0] mem [CH];
  logic [IW:0]   pos;

  // Pack enabled channels into slots 0..N-1 in ascending channel order.
  always_comb begin
    pos = '0;
    for (int k = 0; k < CH; k++) packed_res[k] = '0;
    for (int c = 0; c < CH; c++) begin
      if (mask[c]) begin
        packed_res[pos[IW-1:0]] = samples[c*DW +: DW];
        pos = pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      for (int k = 0; k < CH; k++) mem[k] <= packed_res[k];
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int CH        = 8,
  parameter int FIRST_CYC = 225,
  parameter int SLOT_CYC  = 50,
  localparam int CW   = $clog2(CH + 1),
  localparam int MAXC = (FIRST_CYC > SLOT_CYC) ? FIRST_CYC : SLOT_CYC,
  localparam int TW   = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] n_en,
  output logic [CW-1:0] done_cnt,
  output logic [CW-1:0] n_act,
  output logic          first_done,
  output logic          last_done
);
  logic [TW-1:0] tick;
  logic [TW-1:0] limit;
  logic          run;

  assign limit = (done_cnt == '0) ? TW'(FIRST_CYC - 1) : TW'(SLOT_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick       <= '0;
      done_cnt   <= '0;
      n_act      <= '0;
      run        <= 1'b0;
      first_done <= 1'b0;
      last_done  <= 1'b0;
    end else if (start) begin
      tick       <= '0;
      done_cnt   <= '0;
      n_act      <= n_en;
      run        <= (n_en != '0);
      first_done <= (n_en == '0);
      last_done  <= (n_en == '0);
    end else if (run) begin
      if (tick == limit) begin
        tick       <= '0;
        done_cnt   <= done_cnt + CW'(1);
        first_done <= 1'b1;
        if (done_cnt + CW'(1) == n_act) begin
          last_done <= 1'b1;
          run       <= 1'b0;
        end
      end else begin
        tick <= tick + TW'(1);
      end
    end
  end

  p_done_bound_r6: assert property (@(posedge clk) disable iff (rst)
    done_cnt <= n_act);
  p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
    start |=> (done_cnt == '0));
  p_last_after_first_r6: assert property (@(posedge clk) disable iff (rst)
    last_done |-> first_done);
  p_single_step_r6: assert property (@(posedge clk) disable iff (rst)
    !start |=> (done_cnt == $past(done_cnt)) || (done_cnt == $past(done_cnt) + CW'(1)));
endmodule

// File: rtl/read_port.sv
module read_port
  import conv_seq_pkg::*;
#(
  parameter int CH = 8,
  parameter int DW = 12,
  parameter int OW = 16,
  localparam int CW = $clog2(CH + 1),
  localparam int IW = $clog2(CH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          rd,
  input  logic [CW-1:0] done_cnt,
  input  logic [CW-1:0] n_act,
  input  logic [DW-1:0] mem_word,
  output logic [IW-1:0] mem_addr,
  output logic [OW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_wait
);
  localparam logic [OW-1:0] PAD_WORD = '1;

  logic [CW-1:0] idx;
  resp_e         resp;

  assign mem_addr = idx[IW-1:0];

  always_comb begin
    if (!rd || start)       resp = RESP_IDLE;
    else if (idx < done_cnt) resp = RESP_DATA;
    else if (idx >= n_act)   resp = RESP_PAD;
    else                     resp = RESP_WAIT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      rd_data  <= PAD_WORD;
      rd_valid <= 1'b0;
      rd_wait  <= 1'b0;
    end else begin
      rd_valid <= (resp == RESP_DATA) || (resp == RESP_PAD);
      rd_wait  <= (resp == RESP_WAIT);
      if (start) idx <= '0;
      case (resp)
        RESP_DATA: begin
          rd_data <= {{(OW-DW){1'b1}}, mem_word};
          idx     <= idx + CW'(1);
        end
        RESP_PAD: rd_data <= PAD_WORD;
        default: ;
      endcase
    end
  end

  p_idx_bound_r3: assert property (@(posedge clk) disable iff (rst)
    idx <= n_act);
  p_flags_excl_r13: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && rd_wait));
  p_wait_holds_r7: assert property (@(posedge clk) disable iff (rst)
    rd_wait |-> $stable(rd_data));
  p_start_drops_read_r12: assert property (@(posedge clk) disable iff (rst)
    start |=> (!rd_valid && !rd_wait));
endmodule

// File: rtl/conv_readout_seq.sv
module conv_readout_seq #(
  parameter int CH       = 8,
  parameter int DW       = 12,
  parameter int OW       = 16,
  parameter int CLK_MHZ  = 250,
  parameter int FIRST_NS = 900,
  parameter int SLOT_NS  = 200,
  localparam int CW        = $clog2(CH + 1),
  localparam int IW        = $clog2(CH),
  localparam int FIRST_CYC = (FIRST_NS * CLK_MHZ) / 1000,
  localparam int SLOT_CYC  = (SLOT_NS * CLK_MHZ) / 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CH-1:0]    cfg_mask,
  input  logic             start,
  input  logic             rd,
  input  logic [CH*DW-1:0] samples,
  output logic [OW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             rd_wait,
  output logic             eoc_n,
  output logic             eolc_n
);
  logic [CH-1:0] mask_q;
  logic [CW-1:0] n_en;
  logic [CW-1:0] done_cnt;
  logic [CW-1:0] n_act;
  logic [IW-1:0] mem_addr;
  logic [DW-1:0] mem_word;
  logic          first_done;
  logic          last_done;

  always_ff @(posedge clk) begin
    if (rst)         mask_q <= '1;
    else if (cfg_we) mask_q <= cfg_mask;
  end

  assign n_en = CW'($countones(mask_q));

  capture_store #(.CH(CH), .DW(DW)) u_store (
    .clk     (clk),
    .start   (start),
    .mask    (mask_q),
    .samples (samples),
    .rd_addr (mem_addr),
    .rd_word (mem_word)
  );

  slot_timer #(.CH(CH), .FIRST_CYC(FIRST_CYC), .SLOT_CYC(SLOT_CYC)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .n_en       (n_en),
    .done_cnt   (done_cnt),
    .n_act      (n_act),
    .first_done (first_done),
    .last_done  (last_done)
  );

  read_port #(.CH(CH), .DW(DW), .OW(OW)) u_port (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rd       (rd),
    .done_cnt (done_cnt),
    .n_act    (n_act),
    .mem_word (mem_word),
    .mem_addr (mem_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .rd_wait  (rd_wait)
  );

  assign eoc_n  = ~first_done;
  assign eolc_n = ~last_done;

  p_mask_load_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (mask_q == $past(cfg_mask)));
  p_empty_mask_r10: assert property (@(posedge clk) disable iff (rst)
    (start && mask_q == '0) |=> (!eoc_n && !eolc_n));
endmodule

// File: tb/conv_readout_seq_test.sv
module conv_readout_seq_test;
  localparam int CH = 8, DW = 12, OW = 16;
  localparam int FIRST = 225;  // 900 ns at 250 MHz
  localparam int SLOT  = 50;   // 200 ns at 250 MHz

  logic clk = 1'b0, rst = 1'b1, cfg_we = 1'b0, start = 1'b0, rd = 1'b0;
  logic [CH-1:0]    cfg_mask = '0;
  logic [CH*DW-1:0] samples  = '0;
  logic [OW-1:0]    rd_data;
  logic             rd_valid, rd_wait, eoc_n, eolc_n;

  conv_readout_seq uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mask(cfg_mask), .start(start),
    .rd(rd), .samples(samples), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_wait(rd_wait), .eoc_n(eoc_n), .eolc_n(eolc_n)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  string phase = "R11";
  bit armed = 0, finished = 0;

  // reference model state
  logic [CH-1:0] m_mask;
  int m_q[$];
  int m_n = 0, m_idx = 0, m_age = 0;
  bit m_started = 0;
  logic [OW-1:0] e_data;
  logic e_valid, e_wait, e_eoc_n, e_eolc_n;

  function automatic int dcount(int age, int n);
    int c = 0;
    for (int k = 0; k < n; k++) if (FIRST + k * SLOT <= age) c++;
    return c;
  endfunction

  always @(posedge clk) begin
    int done_b, done_a;
    armed = 1;
    if (rst) begin
      m_mask = '1; m_n = 0; m_idx = 0; m_age = 0; m_started = 0; m_q.delete();
      e_data = 16'hFFFF; e_valid = 0; e_wait = 0; e_eoc_n = 1; e_eolc_n = 1;
    end else begin
      done_b = m_started ? dcount(m_age, m_n) : 0;
      e_valid = 0; e_wait = 0;
      if (start) begin
        m_q.delete();
        for (int c = 0; c < CH; c++)
          if (m_mask[c]) m_q.push_back(int'(samples[c*DW +: DW]));
        m_n = m_q.size(); m_idx = 0; m_age = 0; m_started = 1;
      end else begin
        if (m_started && m_age < 100000) m_age++;
        if (rd) begin
          if (m_idx < done_b) begin
            e_valid = 1; e_data = 16'hF000 | 16'(m_q[m_idx]); m_idx++;
          end else if (m_idx >= m_n) begin
            e_valid = 1; e_data = 16'hFFFF;
          end else e_wait = 1;
        end
      end
      done_a = m_started ? dcount(m_age, m_n) : 0;
      e_eoc_n  = !(m_started && (m_n == 0 || done_a >= 1));
      e_eolc_n = !(m_started && done_a >= m_n);
      if (cfg_we) m_mask = cfg_mask;
    end
  end

  task automatic chk(string tag, logic [OW-1:0] act, logic [OW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s (%s) actual=%h expected=%h t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk("R3/R4 rd_data", rd_data, e_data);
      chk("R7/R8/R13 rd_valid", 16'(rd_valid), 16'(e_valid));
      chk("R7 rd_wait", 16'(rd_wait), 16'(e_wait));
      chk("R5/R9 eoc_n", 16'(eoc_n), 16'(e_eoc_n));
      chk("R6/R9 eolc_n", 16'(eolc_n), 16'(e_eolc_n));
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic do_start();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask
  task automatic do_read(int n);
    repeat (n) begin @(negedge clk); rd = 1; @(negedge clk); rd = 0; end
  endtask
  task automatic do_cfg(logic [CH-1:0] m);
    @(negedge clk); cfg_we = 1; cfg_mask = m; @(negedge clk); cfg_we = 0;
  endtask
  task automatic new_samples();
    for (int c = 0; c < CH; c++) samples[c*DW +: DW] = DW'($urandom);
  endtask

  initial begin
    idle(3); rst = 0;
    phase = "R11"; idle(2); do_read(2);
    // R1: default mask enables all; early reads stall (R7); boundary at first slot (R5)
    phase = "R1"; new_samples(); do_start();
    phase = "R7"; do_read(3);
    phase = "R5"; idle(FIRST - 9); do_read(4);
    phase = "R6"; idle(8 * SLOT); do_read(8);
    phase = "R8"; do_read(3);
    // R2/R3/R4: sparse mask, inputs change right after start
    phase = "R3"; do_cfg(8'b1010_0101); new_samples(); do_start();
    phase = "R2"; new_samples(); idle(FIRST + 4 * SLOT);
    phase = "R4"; do_read(6);
    // R9: restart in the middle of a readout
    phase = "R9"; do_cfg(8'b0111_1110); new_samples(); do_start();
    idle(FIRST + SLOT); do_read(2); new_samples(); do_start(); idle(3);
    idle(FIRST + 6 * SLOT); do_read(7);
    // R6: one channel only, flags fall together
    phase = "R6"; do_cfg(8'h80); new_samples(); do_start(); idle(FIRST + 2); do_read(2);
    // R10: empty mask
    phase = "R10"; do_cfg(8'h00); do_start(); do_read(3);
    // R12: start and read in the same cycle
    phase = "R12"; do_cfg(8'h0F); new_samples();
    @(negedge clk); start = 1; rd = 1; @(negedge clk); start = 0; rd = 0;
    idle(FIRST + 4 * SLOT); do_read(5);
    idle(4);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog (%s) actual=hung expected=finished", phase);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule